// File: doc/BRIEF.md
# Edge-Triggered Vector Flag Unit

This block watches a bank of 32 event lines on behalf of a small sequencer. Four trigger vectors are available. Each has its own enable, a 5-bit selector that picks one of the event lines, and a polarity bit. When a vector is enabled and the chosen edge appears on its line, the vector's flag is set. The flag stays set until software clears it. Software can clear a flag in two ways: write a zero into the flag register, or write a one into a separate clear-strobe register.

Edge detection is applied to the selected line after it has been XORed with the polarity bit. As a result, software can fire a vector on its own. It selects a line that holds still and then flips the polarity bit twice, which produces exactly one trigger.

The sequencer side carries a sleep indication in and returns two things: a wake request and the number of the vector to run. While the sequencer sleeps, the number follows the lowest-index pending flag. While it runs, the number stays frozen, so the next vector is offered only after it goes back to sleep.

Top module: `evvec_unit`

## Requirements
- R1: After a synchronous reset, every configuration field and every flag is 0, `wake_req` is 0 and `vec_sel` is 0.
- R2: Configuration word 0 (address 0) holds vectors 0 and 1, and word 1 (address 1) holds vectors 2 and 3. In each word the even vector sits at bits 4:0 (source), bit 5 (enable) and bit 6 (polarity). The odd vector sits at bits 12:8, 13 and 14. A read returns the stored fields, and bit 7 and bits 31:15 read as 0 whatever was written to them.
- R3: For an enabled vector, polarity 0 reacts to a rising edge of the selected line and polarity 1 to a falling edge. The flag is visible at bit n of the flag register (address 2, bits 3:0) one cycle after the edge is presented.
- R4: A disabled vector never sets its flag, whatever its line does.
- R5: On an enabled vector whose line holds still, flipping polarity 0 to 1 and back to 0 sets the flag exactly once. After the flag is cleared it stays clear.
- R6: A set flag stays set across any later activity on its line until software clears it.
- R7: A write to the flag register clears every flag whose bit is written as 0. Writing 1 leaves a flag unchanged and never sets it.
- R8: Writing 1 to bit n of the clear-strobe register (address 3) clears flag n, and that register always reads 0.
- R9: When an edge and a software clear of the same flag land in the same cycle, the flag ends up set.
- R10: `wake_req` is 1 exactly when `seq_sleeping` is 1 and at least one flag is set.
- R11: While `seq_sleeping` is 1, `vec_sel` is the lowest index among the set flags. While it is 0, `vec_sel` holds the value it had in the last sleeping cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 32 | Event line levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| seq_sleeping | input | 1 | Sequencer is asleep |
| wake_req | output | 1 | Wake/execute request |
| vec_sel | output | 2 | Vector number to execute |

## Verification
The hardest case to reach from the ports is a hardware edge and a software clear of the same flag landing in the same clock. To get there, the bench first sets the flag and returns the line to its idle level. It then raises the line in the same cycle as a clear-strobe write, and repeats this with a zero written to the flag register. The bench also checks the case where the sequencer is awake and a lower-index flag arrives: the frozen vector number must not move until sleep returns. A seeded random phase then mixes line toggles, configuration writes and sleep changes, and compares the result against a cycle model kept in the bench.

// File: rtl/evvec_pkg.sv
package evvec_pkg;

    localparam int VEC_N        = 4;
    localparam int SRC_N        = 32;
    localparam int SEL_W        = $clog2(SRC_N);
    localparam int DATA_W       = 32;
    localparam int VEC_IDX_W    = $clog2(VEC_N);
    localparam int CFG_WORDS    = VEC_N / 2;
    localparam int FLAG_ADDR    = CFG_WORDS;
    localparam int CLR_ADDR     = CFG_WORDS + 1;
    localparam int ADDR_W       = $clog2(CFG_WORDS + 2);
    localparam int FIELD_STRIDE = 8;

    // Per-vector configuration, packed as {pol, en, sel} = bits 6, 5, 4:0
    typedef struct packed {
        logic             pol;
        logic             en;
        logic [SEL_W-1:0] sel;
    } vec_cfg_t;

    localparam int CFG_W = $bits(vec_cfg_t);

    // Lowest set index; 0 when nothing is set
    function automatic logic [VEC_IDX_W-1:0] lowest_set(input logic [VEC_N-1:0] v);
        logic [VEC_IDX_W-1:0] idx;
        idx = '0;
        for (int i = VEC_N - 1; i >= 0; i--) begin
            if (v[i]) idx = VEC_IDX_W'(i);
        end
        return idx;
    endfunction

    // Two vector fields into one register word
    function automatic logic [DATA_W-1:0] pack_pair(input vec_cfg_t even_f, input vec_cfg_t odd_f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_W-1:0]             = even_f;
        w[FIELD_STRIDE +: CFG_W] = odd_f;
        return w;
    endfunction

endpackage

// File: rtl/evvec_cfg_regs.sv
module evvec_cfg_regs
    import evvec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CFG_W-1:0]           even_field,
    input  logic [CFG_W-1:0]           odd_field,
    output vec_cfg_t [VEC_N-1:0]       cfg
);

    for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[2*w]   <= '0;
                cfg[2*w+1] <= '0;
            end else if (wr && (addr == ADDR_W'(w))) begin
                cfg[2*w]   <= vec_cfg_t'(even_field);
                cfg[2*w+1] <= vec_cfg_t'(odd_field);
            end
        end
    end

endmodule

// File: rtl/evvec_edge_det.sv
module evvec_edge_det
    import evvec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_N-1:0]     ev,
    input  vec_cfg_t [VEC_N-1:0] cfg,
    output logic [VEC_N-1:0]     hit
);

    logic [VEC_N-1:0] level;
    logic [VEC_N-1:0] level_q;

    for (genvar g = 0; g < VEC_N; g++) begin : g_vec
        // Polarity folded in before the edge, so a polarity flip is itself an edge
        assign level[g] = ev[cfg[g].sel] ^ cfg[g].pol;
        assign hit[g]   = cfg[g].en & level[g] & ~level_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level;
    end

endmodule

// File: rtl/evvec_flag_store.sv
module evvec_flag_store
    import evvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [VEC_N-1:0]  wbits,
    input  logic [VEC_N-1:0]  hit,
    output logic [VEC_N-1:0]  flags
);

    logic [VEC_N-1:0] flags_d;

    always_comb begin
        flags_d = flags;
        if (wr && addr == ADDR_W'(FLAG_ADDR)) flags_d = flags_d & wbits;
        if (wr && addr == ADDR_W'(CLR_ADDR))  flags_d = flags_d & ~wbits;
        flags_d = flags_d | hit;   // hardware set overrides clear
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

endmodule

// File: rtl/evvec_arbiter.sv
module evvec_arbiter
    import evvec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 seq_sleeping,
    input  logic [VEC_N-1:0]     flags,
    output logic                 wake_req,
    output logic [VEC_IDX_W-1:0] vec_sel
);

    logic [VEC_IDX_W-1:0] pick;
    logic [VEC_IDX_W-1:0] held_q;

    assign pick     = lowest_set(flags);
    assign wake_req = seq_sleeping & (|flags);
    assign vec_sel  = seq_sleeping ? pick : held_q;

    always_ff @(posedge clk) begin
        if (rst)               held_q <= '0;
        else if (seq_sleeping) held_q <= pick;
    end

endmodule

// File: rtl/evvec_unit.sv
module evvec_unit
    import evvec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SRC_N-1:0]     ev_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 seq_sleeping,
    output logic                 wake_req,
    output logic [VEC_IDX_W-1:0] vec_sel
);

    vec_cfg_t [VEC_N-1:0] cfg;
    logic [VEC_N-1:0]     edge_hit;
    logic [VEC_N-1:0]     flag_q;
    logic                 wdata_unused;

    assign wdata_unused = ^{reg_wdata[DATA_W-1:FIELD_STRIDE+CFG_W], reg_wdata[FIELD_STRIDE-1:CFG_W]};

    evvec_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .even_field (reg_wdata[CFG_W-1:0]),
        .odd_field  (reg_wdata[FIELD_STRIDE +: CFG_W]),
        .cfg        (cfg)
    );

    evvec_edge_det u_edge (
        .clk (clk),
        .rst (rst),
        .ev  (ev_in),
        .cfg (cfg),
        .hit (edge_hit)
    );

    evvec_flag_store u_flags (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wbits (reg_wdata[VEC_N-1:0]),
        .hit   (edge_hit),
        .flags (flag_q)
    );

    evvec_arbiter u_arb (
        .clk          (clk),
        .rst          (rst),
        .seq_sleeping (seq_sleeping),
        .flags        (flag_q),
        .wake_req     (wake_req),
        .vec_sel      (vec_sel)
    );

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < CFG_WORDS)
            reg_rdata = pack_pair(cfg[2*int'(reg_addr)], cfg[2*int'(reg_addr)+1]);
        else if (reg_addr == ADDR_W'(FLAG_ADDR))
            reg_rdata[VEC_N-1:0] = flag_q;
    end

endmodule

// File: rtl/evvec_checker.sv
module evvec_checker
    import evvec_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [VEC_N-1:0]     flags,
    input logic [VEC_N-1:0]     edges,
    input logic                 seq_sleeping,
    input logic                 wake_req,
    input logic [VEC_IDX_W-1:0] vec_sel,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_rdata
);

    for (genvar i = 0; i < VEC_N; i++) begin : g_chk
        // R7: only a hardware edge may raise a flag
        assert_set_by_edge_only_R7: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[i]) |-> $past(edges[i]));
        // R9: an edge always leaves its flag set, even against a clear
        assert_edge_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
            edges[i] |=> flags[i]);
    end

    assert_clear_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(CLR_ADDR)) |-> (reg_rdata == '0));

    assert_wake_pending_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_sleeping && (|flags)) |-> wake_req);

    assert_no_wake_awake_R10: assert property (@(posedge clk) disable iff (rst)
        !seq_sleeping |-> !wake_req);

    assert_hold_while_awake_R11: assert property (@(posedge clk) disable iff (rst)
        (!seq_sleeping && $past(!seq_sleeping)) |-> $stable(vec_sel));

    assert_lowest_first_R11: assert property (@(posedge clk) disable iff (rst)
        (seq_sleeping && flags[0]) |-> (vec_sel == '0));

endmodule

bind evvec_unit evvec_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .flags        (flag_q),
    .edges        (edge_hit),
    .seq_sleeping (seq_sleeping),
    .wake_req     (wake_req),
    .vec_sel      (vec_sel),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/evvec_unit_tb.sv
`timescale 1ns/100ps
module evvec_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ev_in;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        seq_sleeping;
    logic        wake_req;
    logic [1:0]  vec_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evvec_unit u_dut (
        .clk(clk), .rst(rst), .ev_in(ev_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_sleeping(seq_sleeping),
        .wake_req(wake_req), .vec_sel(vec_sel)
    );

    // ---------------- bench model, derived from the requirements ----------------
    logic [4:0] m_sel [4];
    logic       m_en  [4];
    logic       m_pol [4];
    logic [3:0] m_prev, m_flags, m_hit, m_nprev, m_nf;
    logic [1:0] m_held;

    function automatic logic [1:0] first_one(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return 2'(i);
        return 2'd0;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] a);
        logic [31:0] r;
        r = '0;
        if (a < 2) begin
            r[4:0]   = m_sel[2*a];   r[5]  = m_en[2*a];   r[6]  = m_pol[2*a];
            r[12:8]  = m_sel[2*a+1]; r[13] = m_en[2*a+1]; r[14] = m_pol[2*a+1];
        end else if (a == 2) begin
            r[3:0] = m_flags;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_en[i] = 1'b0; m_pol[i] = 1'b0; end
            m_prev = '0; m_flags = '0; m_held = '0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                m_nprev[i] = ev_in[m_sel[i]] ^ m_pol[i];
                m_hit[i]   = m_en[i] & m_nprev[i] & ~m_prev[i];
            end
            if (seq_sleeping) m_held = first_one(m_flags);
            m_nf = m_flags;
            if (reg_wr && reg_addr == 2'd2) m_nf = m_nf & reg_wdata[3:0];
            if (reg_wr && reg_addr == 2'd3) m_nf = m_nf & ~reg_wdata[3:0];
            m_nf = m_nf | m_hit;
            if (reg_wr && reg_addr < 2) begin
                m_sel[2*reg_addr]   = reg_wdata[4:0];
                m_en[2*reg_addr]    = reg_wdata[5];
                m_pol[2*reg_addr]   = reg_wdata[6];
                m_sel[2*reg_addr+1] = reg_wdata[12:8];
                m_en[2*reg_addr+1]  = reg_wdata[13];
                m_pol[2*reg_addr+1] = reg_wdata[14];
            end
            m_flags = m_nf;
            m_prev  = m_nprev;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [31:0] e, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic compare_model();
        logic [31:0] er;
        logic [1:0]  es;
        er = model_read(reg_addr);
        es = seq_sleeping ? first_one(m_flags) : m_held;
        chk(reg_rdata == er, (reg_addr == 2'd2) ? "R6" : (reg_addr == 2'd3) ? "R8" : "R2", reg_rdata, er);
        chk(wake_req == (seq_sleeping && (|m_flags)), "R10", 32'(wake_req), 32'(seq_sleeping && (|m_flags)));
        chk(vec_sel == es, "R11", 32'(vec_sel), 32'(es));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst = 1'b1; ev_in = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; seq_sleeping = 1'b1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        expect_reg(2'd0, 32'h0, "R1");
        expect_reg(2'd1, 32'h0, "R1");
        expect_reg(2'd2, 32'h0, "R1");
        chk(wake_req == 1'b0, "R1", 32'(wake_req), 32'h0);
        chk(vec_sel == 2'd0, "R1", 32'(vec_sel), 32'h0);
        idle(1);

        // R2: field layout, reserved bits masked. v0: src3 en pol0; v1: src7 en pol1
        wr_reg(2'd0, 32'hFFFF_67A3);
        expect_reg(2'd0, 32'h0000_6723, "R2");
        idle(2);                       // polarity 1 on a low line fires vector 1 once
        wr_reg(2'd3, 32'hF);
        expect_reg(2'd2, 32'h0, "R8");

        // R3: rising edge on line 3 (pol 0), falling edge on line 7 (pol 1)
        ev_in[3] = 1'b1; idle(1);
        expect_reg(2'd2, 32'h1, "R3");
        ev_in[7] = 1'b1; idle(1);
        expect_reg(2'd2, 32'h1, "R3");
        ev_in[7] = 1'b0; idle(1);
        expect_reg(2'd2, 32'h3, "R3");

        // R6: sticky
        ev_in[3] = 1'b0; ev_in[7] = 1'b1; idle(3);
        expect_reg(2'd2, 32'h3, "R6");
        ev_in[7] = 1'b0; idle(1);
        chk(wake_req == 1'b1, "R10", 32'(wake_req), 32'h1);
        chk(vec_sel == 2'd0, "R11", 32'(vec_sel), 32'h0);

        // R7: write 0 clears, write 1 has no effect
        wr_reg(2'd2, 32'h2);
        expect_reg(2'd2, 32'h2, "R7");
        wr_reg(2'd2, 32'hF);
        expect_reg(2'd2, 32'h2, "R7");
        chk(vec_sel == 2'd1, "R11", 32'(vec_sel), 32'h1);

        // R11: frozen while awake, even when a lower index arrives
        seq_sleeping = 1'b0; #1;
        chk(wake_req == 1'b0, "R10", 32'(wake_req), 32'h0);
        chk(vec_sel == 2'd1, "R11", 32'(vec_sel), 32'h1);
        @(negedge clk);
        ev_in[3] = 1'b1; idle(1);
        expect_reg(2'd2, 32'h3, "R3");
        chk(vec_sel == 2'd1, "R11", 32'(vec_sel), 32'h1);
        seq_sleeping = 1'b1; #1;
        chk(vec_sel == 2'd0, "R11", 32'(vec_sel), 32'h0);
        @(negedge clk);
        ev_in[3] = 1'b0;

        // R8: strobe clear, reads zero
        wr_reg(2'd3, 32'h3);
        expect_reg(2'd2, 32'h0, "R8");
        expect_reg(2'd3, 32'h0, "R8");
        @(negedge clk);

        // R4: vector 1 disabled (src7 pol0), vector 0 unchanged
        wr_reg(2'd0, 32'h0000_0723);
        for (int k = 0; k < 3; k++) begin
            ev_in[7] = 1'b1; idle(1);
            ev_in[7] = 1'b0; idle(1);
        end
        expect_reg(2'd2, 32'h0, "R4");

        // R5: vector 2 on static low line 10, toggle polarity twice
        wr_reg(2'd1, 32'h0000_002A);
        idle(2);
        expect_reg(2'd2, 32'h0, "R5");
        wr_reg(2'd1, 32'h0000_006A);
        wr_reg(2'd1, 32'h0000_002A);
        idle(2);
        expect_reg(2'd2, 32'h4, "R5");
        wr_reg(2'd3, 32'h4);
        idle(3);
        expect_reg(2'd2, 32'h0, "R5");

        // R9: vector 3 on line 12 pol0, set beats same-cycle clear
        wr_reg(2'd1, 32'h0000_2C2A);
        ev_in[12] = 1'b1; idle(1);
        expect_reg(2'd2, 32'h8, "R3");
        ev_in[12] = 1'b0; idle(1);
        ev_in[12] = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h8;
        @(negedge clk); reg_wr = 1'b0;
        expect_reg(2'd2, 32'h8, "R9");
        ev_in[12] = 1'b0; idle(1);
        ev_in[12] = 1'b1; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0;
        expect_reg(2'd2, 32'h8, "R9");
        @(negedge clk);

        // Random phase against the bench model
        for (int c = 0; c < 4000; c++) begin
            compare_model();
            for (int f = 0; f < 3; f++) ev_in[$urandom % 32] ^= 1'b1;
            reg_wr    = ($urandom % 5) == 0;
            reg_addr  = 2'($urandom % 4);
            reg_wdata = $urandom;
            if (($urandom % 8) == 0) seq_sleeping = ~seq_sleeping;
            @(negedge clk);
        end
        reg_wr = 1'b0;
        @(negedge clk);
        compare_model();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule